// File: doc/BRIEF.md
# Register Rename Unit with Free List

This block renames architectural destination registers onto a larger pool of physical registers as instructions enter a dispatch queue. It keeps a map table from the 32 architectural indices to physical tags and a circular free list of unused tags. It also stores map snapshots at renamed branches, so that a mispredicted branch can be undone in a single cycle. Index 0 is the hard-wired zero. It is never renamed and always reads as physical tag 0.

One instruction is presented per cycle. It carries two source indices, a destination index and a branch flag. In the same cycle the block returns the physical tags of both sources. For an instruction that writes a register, it also returns the newly allocated tag and the tag that the new tag displaces. The displaced tag travels with the instruction down the pipeline. When the instruction commits, the commit logic hands that tag back on one of several commit lanes, and the block returns it to the free list. Branches resolve oldest first. A correct resolution drops the oldest snapshot. A misprediction restores the map from it and moves the free-list read pointer back, so every tag allocated to a squashed instruction becomes free again.

Renaming stalls when a register-writing instruction finds the free list empty, when a branch finds every snapshot slot in use, and in the cycle of a misprediction.

Top module: `reg_rename_unit`

## Requirements
- R1: After reset, architectural index i maps to physical tag i for every i. The free list holds tags NUM_ARCH to NUM_PHYS-1 in ascending order, so the first allocation returns tag 32 with the default parameters.
- R2: Index 0 is never renamed. A source index of 0 yields tag 0. A destination index of 0 allocates nothing, and `tag_dst` and `tag_prev` read 0 in that case.
- R3: In the cycle of the request, each source tag equals the physical tag most recently allocated to that architectural index by an accepted, unsquashed instruction. A request's own destination does not affect its own sources.
- R4: An accepted non-branch request with a nonzero destination takes the tag at the head of the free list, in FIFO order. `tag_prev` carries the tag previously mapped to that destination.
- R5: A commit lane with `cmt_valid` and `cmt_has_dst` set returns its `cmt_prev` tag to the tail of the free list. One cycle later `rel_valid`/`rel_tag` of that lane report the release, and the tag can be allocated from that cycle on.
- R6: A request that needs a destination stalls (`req_stall`=1) while the free list is empty. A stalled request changes no state and is dropped.
- R7: Each accepted branch stores a snapshot of the map and of the free-list read pointer. A branch request stalls while NUM_CKPT snapshots are outstanding. Stall is decided from the snapshot count at the start of the cycle.
- R8: When `res_valid` and `res_mispredict` are set, the block restores the map from the oldest snapshot and discards every snapshot. Tags allocated since that snapshot become free again and are handed out first, in their original order. Any request in that cycle stalls.
- R9: When `res_valid` is set with `res_mispredict` clear, the block drops the oldest snapshot. From the next cycle a further branch can be accepted, and a later misprediction restores the next-older snapshot.
- R10: A branch request allocates nothing and ignores its destination index. `tag_dst` and `tag_prev` read 0, and the map entry of that index is left unchanged.
- R11: Up to COMMIT_W lanes release tags in one cycle. The lanes enter the free list in lane order, lane 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Rename request present |
| req_src_a | input | 5 | First source architectural index |
| req_src_b | input | 5 | Second source architectural index |
| req_dst | input | 5 | Destination architectural index (0 = none) |
| req_branch | input | 1 | Request is a branch; takes a snapshot |
| req_stall | output | 1 | Request not accepted this cycle |
| tag_src_a | output | 6 | Physical tag of first source |
| tag_src_b | output | 6 | Physical tag of second source |
| tag_dst | output | 6 | Newly allocated physical tag, else 0 |
| tag_prev | output | 6 | Tag displaced by the new mapping, else 0 |
| cmt_valid | input | COMMIT_W | Per-lane commit strobe, lanes in program order |
| cmt_has_dst | input | COMMIT_W | Committed instruction carried a destination |
| cmt_prev | input | COMMIT_W*6 | Displaced tag per lane to release |
| res_valid | input | 1 | Oldest outstanding branch resolves |
| res_mispredict | input | 1 | That branch was mispredicted |
| rel_valid | output | COMMIT_W | Registered per-lane release strobe |
| rel_tag | output | COMMIT_W*6 | Registered per-lane released tag |

## Verification
The tag outputs and `req_stall` are combinational. They are due in the same cycle as the request, so the bench drives inputs on the falling edge and compares them 1 ns later, before the rising edge commits the request. Releases show on `rel_valid`/`rel_tag` one cycle after the commit. A released tag can be handed out from that same later cycle, and the restored map after a misprediction is visible in the first cycle after the resolution. The behavioural model in the bench advances its map, its free-list queue and its snapshots only at the rising edge. Its expectations for the following falling-edge comparison therefore carry exactly one register stage.

// File: rtl/rn_pkg.sv
`timescale 1ns/1ps
package rn_pkg;
  // Number of set bits in m below bit position n (n = width gives the full count).
  function automatic int ones_below(logic [31:0] m, int n);
    int c;
    c = 0;
    for (int i = 0; i < 32; i++) begin
      if (i < n && m[i]) c++;
    end
    return c;
  endfunction

  // Next index of a ring of the given depth.
  function automatic int ring_next(int p, int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/rn_free_list.sv
`timescale 1ns/1ps
module rn_free_list #(
  parameter int NPHYS = 64,
  parameter int NARCH = 32,
  parameter int CW    = 2,
  parameter int PW    = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pop,
  input  logic [CW-1:0]   push_v,
  input  logic [CW*PW-1:0] push_tag,
  input  logic            restore,
  input  logic [PW-1:0]   restore_head,
  output logic [PW-1:0]   head_tag,
  output logic [PW-1:0]   head_ptr,
  output logic            empty,
  output logic [PW:0]     free_count
);
  import rn_pkg::*;
  localparam int FREE0 = NPHYS - NARCH;

  logic [PW-1:0] mem [NPHYS];
  logic [PW-1:0] head, tail;
  logic [PW:0]   cnt;
  logic [PW:0]   npush;
  logic [PW-1:0] since;

  assign npush      = (PW+1)'(ones_below(32'(push_v), CW));
  assign since      = head - restore_head;
  assign head_tag   = mem[head];
  assign head_ptr   = head;
  assign empty      = (cnt == '0);
  assign free_count = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) mem[i] <= (i < FREE0) ? PW'(i + NARCH) : '0;
      head <= '0;
      tail <= PW'(FREE0);
      cnt  <= (PW+1)'(FREE0);
    end else begin
      for (int l = 0; l < CW; l++) begin
        if (push_v[l]) mem[tail + PW'(ones_below(32'(push_v), l))] <= push_tag[l*PW +: PW];
      end
      tail <= tail + npush[PW-1:0];
      if (restore) begin
        head <= restore_head;
        cnt  <= cnt + {1'b0, since} + npush;
      end else begin
        head <= head + PW'(pop);
        cnt  <= cnt + npush - (PW+1)'(pop);
      end
    end
  end
endmodule

// File: rtl/rn_map_table.sv
`timescale 1ns/1ps
module rn_map_table #(
  parameter int NARCH = 32,
  parameter int PW    = 6,
  parameter int AW    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      rd_a,
  input  logic [AW-1:0]      rd_b,
  input  logic [AW-1:0]      rd_c,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_arch,
  input  logic [PW-1:0]      wr_tag,
  input  logic               restore,
  input  logic [NARCH*PW-1:0] restore_map,
  output logic [PW-1:0]      tag_a,
  output logic [PW-1:0]      tag_b,
  output logic [PW-1:0]      tag_c,
  output logic [NARCH*PW-1:0] snap
);
  logic [PW-1:0] map [NARCH];

  assign tag_a = map[rd_a];
  assign tag_b = map[rd_b];
  assign tag_c = map[rd_c];

  for (genvar g = 0; g < NARCH; g++) begin : g_snap
    assign snap[g*PW +: PW] = map[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NARCH; i++) map[i] <= PW'(i);
    end else if (restore) begin
      for (int i = 0; i < NARCH; i++) map[i] <= restore_map[i*PW +: PW];
    end else if (wr_en) begin
      map[wr_arch] <= wr_tag;
    end
  end
endmodule

// File: rtl/rn_ckpt_queue.sv
`timescale 1ns/1ps
module rn_ckpt_queue #(
  parameter int NCKPT = 4,
  parameter int DW    = 198
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          flush,
  output logic [DW-1:0] oldest,
  output logic          full,
  output logic          empty
);
  import rn_pkg::*;
  localparam int PTR_W = (NCKPT > 1) ? $clog2(NCKPT) : 1;
  localparam int CNT_W = $clog2(NCKPT + 1);

  logic [DW-1:0]    mem [NCKPT];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  assign oldest = mem[rd_ptr];
  assign full   = (cnt == CNT_W'(NCKPT));
  assign empty  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCKPT; i++) mem[i] <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      rd_ptr <= wr_ptr;
      cnt    <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= PTR_W'(ring_next(int'(wr_ptr), NCKPT));
      end
      if (pop) rd_ptr <= PTR_W'(ring_next(int'(rd_ptr), NCKPT));
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/reg_rename_unit.sv
`timescale 1ns/1ps
module reg_rename_unit #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  parameter int NUM_CKPT = 4,
  parameter int COMMIT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [4:0]               req_src_a,
  input  logic [4:0]               req_src_b,
  input  logic [4:0]               req_dst,
  input  logic                     req_branch,
  output logic                     req_stall,
  output logic [5:0]               tag_src_a,
  output logic [5:0]               tag_src_b,
  output logic [5:0]               tag_dst,
  output logic [5:0]               tag_prev,
  input  logic [COMMIT_W-1:0]      cmt_valid,
  input  logic [COMMIT_W-1:0]      cmt_has_dst,
  input  logic [COMMIT_W*6-1:0]    cmt_prev,
  input  logic                     res_valid,
  input  logic                     res_mispredict,
  output logic [COMMIT_W-1:0]      rel_valid,
  output logic [COMMIT_W*6-1:0]    rel_tag
);
  localparam int AW     = $clog2(NUM_ARCH);
  localparam int PW     = $clog2(NUM_PHYS);
  localparam int SNAP_W = NUM_ARCH * PW;
  localparam int CK_W   = SNAP_W + PW;

  // Named internal events, brought out for the checker.
  logic needs_reg, mis_now, fire;
  logic ev_alloc, ev_ckpt, ev_rollback, ev_ckpt_pop;
  logic [COMMIT_W-1:0] ev_release;

  logic [PW-1:0]     fl_head_tag, fl_head_ptr, map_prev;
  logic              fl_empty, ck_full, ck_empty;
  logic [PW:0]       free_count;
  logic [SNAP_W-1:0] map_snap;
  logic [CK_W-1:0]   ck_oldest;

  assign needs_reg   = (req_dst != '0) && !req_branch;
  assign mis_now     = res_valid && res_mispredict;
  assign req_stall   = req_valid && (mis_now || (needs_reg && fl_empty) || (req_branch && ck_full));
  assign fire        = req_valid && !req_stall;
  assign ev_alloc    = fire && needs_reg;
  assign ev_ckpt     = fire && req_branch;
  assign ev_rollback = mis_now;
  assign ev_ckpt_pop = res_valid && !res_mispredict;
  assign ev_release  = cmt_valid & cmt_has_dst;

  rn_map_table #(.NARCH(NUM_ARCH), .PW(PW), .AW(AW)) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_a(req_src_a), .rd_b(req_src_b), .rd_c(req_dst),
    .wr_en(ev_alloc), .wr_arch(req_dst), .wr_tag(fl_head_tag),
    .restore(ev_rollback), .restore_map(ck_oldest[SNAP_W-1:0]),
    .tag_a(tag_src_a), .tag_b(tag_src_b), .tag_c(map_prev),
    .snap(map_snap)
  );

  rn_free_list #(.NPHYS(NUM_PHYS), .NARCH(NUM_ARCH), .CW(COMMIT_W), .PW(PW)) u_free (
    .clk(clk), .rst_n(rst_n),
    .pop(ev_alloc), .push_v(ev_release), .push_tag(cmt_prev),
    .restore(ev_rollback), .restore_head(ck_oldest[SNAP_W +: PW]),
    .head_tag(fl_head_tag), .head_ptr(fl_head_ptr),
    .empty(fl_empty), .free_count(free_count)
  );

  rn_ckpt_queue #(.NCKPT(NUM_CKPT), .DW(CK_W)) u_ckpt (
    .clk(clk), .rst_n(rst_n),
    .push(ev_ckpt), .push_data({fl_head_ptr, map_snap}),
    .pop(ev_ckpt_pop), .flush(ev_rollback),
    .oldest(ck_oldest), .full(ck_full), .empty(ck_empty)
  );

  assign tag_dst  = ev_alloc ? fl_head_tag : '0;
  assign tag_prev = ev_alloc ? map_prev : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_valid <= '0;
      rel_tag   <= '0;
    end else begin
      rel_valid <= ev_release;
      rel_tag   <= cmt_prev;
    end
  end
endmodule

// File: rtl/rn_checker.sv
`timescale 1ns/1ps
module rn_checker #(
  parameter int NARCH = 32,
  parameter int NPHYS = 64,
  parameter int CW    = 2,
  parameter int PW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_branch,
  input logic [4:0]       req_src_a,
  input logic [4:0]       req_dst,
  input logic             req_stall,
  input logic [5:0]       tag_src_a,
  input logic [5:0]       tag_dst,
  input logic [5:0]       tag_prev,
  input logic             res_valid,
  input logic             res_mispredict,
  input logic [CW-1:0]    rel_valid,
  input logic [CW*6-1:0]  rel_tag,
  input logic             ev_alloc,
  input logic             ev_rollback,
  input logic             fl_empty,
  input logic             ck_full,
  input logic             ck_empty,
  input logic [PW:0]      free_count
);
  assert_src_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_src_a == '0 |-> tag_src_a == '0);

  assert_alloc_fresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |-> tag_dst != '0 && tag_dst != tag_prev);

  assert_free_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    free_count <= (PW+1)'(NPHYS - NARCH));

  assert_empty_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_branch && req_dst != '0 && fl_empty |-> req_stall);

  assert_ckpt_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_branch && ck_full |-> req_stall);

  assert_mispredict_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_mispredict && req_valid |-> req_stall);

  assert_rollback_refill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rollback |=> free_count >= $past(free_count));

  assert_resolve_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !ck_empty);

  assert_branch_nodst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_branch |-> tag_dst == '0 && tag_prev == '0);

  for (genvar l = 0; l < CW; l++) begin : g_lane
    assert_release_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid[l] |-> rel_tag[l*6 +: 6] != '0);
  end
endmodule

bind reg_rename_unit rn_checker #(.NARCH(NUM_ARCH), .NPHYS(NUM_PHYS), .CW(COMMIT_W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_branch(req_branch),
  .req_src_a(req_src_a), .req_dst(req_dst), .req_stall(req_stall),
  .tag_src_a(tag_src_a), .tag_dst(tag_dst), .tag_prev(tag_prev),
  .res_valid(res_valid), .res_mispredict(res_mispredict),
  .rel_valid(rel_valid), .rel_tag(rel_tag),
  .ev_alloc(ev_alloc), .ev_rollback(ev_rollback),
  .fl_empty(fl_empty), .ck_full(ck_full), .ck_empty(ck_empty),
  .free_count(free_count)
);

// File: tb/reg_rename_unit_bench.sv
`timescale 1ns/1ps
module reg_rename_unit_bench;
  localparam int NA = 32, NP = 64, NC = 4, CW = 2, PW = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic req_valid, req_branch, req_stall;
  logic [4:0] req_src_a, req_src_b, req_dst;
  logic [5:0] tag_src_a, tag_src_b, tag_dst, tag_prev;
  logic [CW-1:0] cmt_valid, cmt_has_dst, rel_valid;
  logic [CW*PW-1:0] cmt_prev, rel_tag;
  logic res_valid, res_mispredict;

  reg_rename_unit u_reg_rename_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src_a(req_src_a),
    .req_src_b(req_src_b), .req_dst(req_dst), .req_branch(req_branch),
    .req_stall(req_stall), .tag_src_a(tag_src_a), .tag_src_b(tag_src_b),
    .tag_dst(tag_dst), .tag_prev(tag_prev), .cmt_valid(cmt_valid),
    .cmt_has_dst(cmt_has_dst), .cmt_prev(cmt_prev), .res_valid(res_valid),
    .res_mispredict(res_mispredict), .rel_valid(rel_valid), .rel_tag(rel_tag)
  );

  int nchk = 0, nfail = 0;

  // Reference model state
  int rm_map [NA];
  int fl [$];
  int alog [$];
  int rm_ck [NC][NA];
  int ck_mark [NC];
  int nck;
  // Program-order record of accepted instructions (for commit stimulus)
  int p_has [$];
  int p_prev [$];
  bit p_br [$];
  // Expectations
  bit e_stall;
  int e_sa, e_sb, e_dst, e_prev;
  bit e_rv [CW];
  int e_rt [CW];

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NA; i++) rm_map[i] = i;
    fl.delete(); alog.delete();
    for (int t = NA; t < NP; t++) fl.push_back(t);
    nck = 0;
    p_has.delete(); p_prev.delete(); p_br.delete();
    for (int l = 0; l < CW; l++) begin e_rv[l] = 0; e_rt[l] = 0; end
  endtask

  task automatic idle();
    req_valid = 0; req_src_a = 0; req_src_b = 0; req_dst = 0; req_branch = 0;
    cmt_valid = 0; cmt_has_dst = 0; cmt_prev = 0; res_valid = 0; res_mispredict = 0;
  endtask

  task automatic rq(input int sa, input int sb, input int d, input bit br);
    req_valid = 1; req_src_a = 5'(sa); req_src_b = 5'(sb); req_dst = 5'(d); req_branch = br;
  endtask

  // Wait past the falling edge, compute expectations, compare.
  task automatic settle();
    bit needs, mis;
    string ls, lsrc, ldst;
    #1;
    needs = (req_dst != 0) && !req_branch;
    mis = res_valid && res_mispredict;
    e_stall = req_valid && (mis || (needs && fl.size() == 0) || (req_branch && nck == NC));
    e_sa = rm_map[req_src_a];
    e_sb = rm_map[req_src_b];
    e_dst = (needs && fl.size() > 0) ? fl[0] : 0;
    e_prev = needs ? rm_map[req_dst] : 0;
    ls = mis ? "R8" : ((req_branch && nck == NC) ? "R7" : "R6");
    chk(ls, int'(req_stall), int'(e_stall));
    if (req_valid && !e_stall) begin
      lsrc = (req_src_a == 0) ? "R2" : "R3";
      chk(lsrc, int'(tag_src_a), e_sa);
      chk("R3", int'(tag_src_b), e_sb);
      ldst = req_branch ? "R10" : ((req_dst == 0) ? "R2" : "R4");
      chk(ldst, int'(tag_dst), e_dst);
      chk(ldst, int'(tag_prev), e_prev);
    end
    for (int l = 0; l < CW; l++) begin
      chk((e_rv[0] && e_rv[1]) ? "R11" : "R5", int'(rel_valid[l]), int'(e_rv[l]));
      if (e_rv[l]) chk("R5", int'(rel_tag[l*PW +: PW]), e_rt[l]);
    end
  endtask

  // Rising edge: advance the model with the inputs that were checked.
  task automatic tick();
    bit needs, fire;
    int t, idx;
    @(posedge clk);
    needs = (req_dst != 0) && !req_branch;
    fire = req_valid && !e_stall;
    for (int l = 0; l < CW; l++) begin
      e_rv[l] = cmt_valid[l] && cmt_has_dst[l];
      e_rt[l] = int'(cmt_prev[l*PW +: PW]);
      if (e_rv[l]) fl.push_back(e_rt[l]);
    end
    if (res_valid && res_mispredict) begin
      while (alog.size() > ck_mark[0]) fl.push_front(alog.pop_back());
      for (int i = 0; i < NA; i++) rm_map[i] = rm_ck[0][i];
      nck = 0;
      idx = -1;
      for (int i = 0; i < p_br.size(); i++) if (idx < 0 && p_br[i]) idx = i;
      while (p_has.size() > idx + 1) begin
        void'(p_has.pop_back()); void'(p_prev.pop_back()); void'(p_br.pop_back());
      end
      p_br[idx] = 0;
    end else if (res_valid) begin
      for (int k = 0; k < NC - 1; k++) begin
        for (int i = 0; i < NA; i++) rm_ck[k][i] = rm_ck[k+1][i];
        ck_mark[k] = ck_mark[k+1];
      end
      nck--;
      idx = -1;
      for (int i = 0; i < p_br.size(); i++) if (idx < 0 && p_br[i]) idx = i;
      p_br[idx] = 0;
    end
    if (fire) begin
      if (needs) begin
        t = fl.pop_front();
        alog.push_back(t);
        rm_map[req_dst] = t;
      end
      if (req_branch) begin
        for (int i = 0; i < NA; i++) rm_ck[nck][i] = rm_map[i];
        ck_mark[nck] = alog.size();
        nck++;
      end
      p_has.push_back(needs ? 1 : 0);
      p_prev.push_back(e_prev);
      p_br.push_back(req_branch);
    end
    if (nck == 0) alog.delete();
    @(negedge clk);
  endtask

  task automatic pick_commits(input int pct);
    cmt_valid = 0; cmt_has_dst = 0; cmt_prev = 0;
    for (int l = 0; l < CW; l++) begin
      if (p_has.size() > 0 && !p_br[0] && ($urandom % 100) < pct) begin
        cmt_valid[l] = 1;
        cmt_has_dst[l] = p_has[0][0];
        cmt_prev[l*PW +: PW] = PW'(p_prev[0]);
        void'(p_has.pop_front()); void'(p_prev.pop_front()); void'(p_br.pop_front());
      end else break;
    end
  endtask

  function automatic bit has_unres();
    foreach (p_br[i]) if (p_br[i]) return 1;
    return 0;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int x_first, saved10;
    rst_n = 0;
    idle();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset mapping and first free tag
    rq(7, 31, 0, 0); settle();
    chk("R1", int'(tag_src_a), 7); chk("R1", int'(tag_src_b), 31);
    chk("R1", int'(rel_valid), 0); chk("R2", int'(tag_dst), 0);
    tick();
    rq(0, 1, 3, 0); settle();
    chk("R1", int'(tag_dst), 32); chk("R1", int'(tag_prev), 3); chk("R2", int'(tag_src_a), 0);
    tick();
    rq(3, 3, 3, 0); settle();
    chk("R3", int'(tag_src_a), 32); chk("R4", int'(tag_dst), 33); chk("R4", int'(tag_prev), 32);
    tick();
    // R10: branch ignores its destination
    rq(1, 2, 9, 1); settle();
    chk("R10", int'(tag_dst), 0); chk("R10", int'(req_stall), 0);
    tick();
    rq(9, 0, 5, 0); settle();
    chk("R10", int'(tag_src_a), 9); chk("R4", int'(tag_dst), 34);
    tick();
    rq(3, 5, 3, 0); settle();
    chk("R4", int'(tag_dst), 35); chk("R4", int'(tag_prev), 33);
    tick();
    // R8: mispredict stalls the request in the same cycle
    rq(1, 1, 6, 0); res_valid = 1; res_mispredict = 1; settle();
    chk("R8", int'(req_stall), 1);
    tick();
    idle(); rq(3, 5, 6, 0); settle();
    chk("R8", int'(tag_src_a), 33); chk("R8", int'(tag_src_b), 5); chk("R8", int'(tag_dst), 34);
    tick();
    // R11: two lanes in one cycle (first instr has no dest, second releases tag 3)
    idle(); pick_commits(100); settle(); tick();
    idle(); settle();
    chk("R11", int'(rel_valid), 2); chk("R11", int'(rel_tag[PW +: PW]), 3);
    tick();

    // R7 / R9: fill all snapshots
    idle(); pick_commits(100); settle(); tick();
    saved10 = rm_map[10];
    idle(); rq(0, 0, 0, 1); settle(); tick();
    idle(); rq(0, 0, 0, 1); settle(); tick();
    idle(); rq(10, 0, 10, 0); settle(); x_first = e_dst; tick();
    idle(); rq(0, 0, 0, 1); settle(); tick();
    idle(); rq(0, 0, 0, 1); settle(); tick();
    idle(); rq(0, 0, 0, 1); res_valid = 1; settle();
    chk("R7", int'(req_stall), 1);
    tick();
    idle(); rq(0, 0, 0, 1); settle();
    chk("R9", int'(req_stall), 0);
    tick();
    idle(); rq(0, 0, 10, 0); settle(); tick();
    idle(); res_valid = 1; res_mispredict = 1; settle(); tick();
    idle(); rq(10, 0, 12, 0); settle();
    chk("R9", int'(tag_src_a), saved10);
    chk("R8", int'(tag_dst), x_first);
    tick();

    // Random traffic: scarce commits (free list drains), then plentiful
    for (int ph = 0; ph < 2; ph++) begin
      for (int c = 0; c < 1500; c++) begin
        idle();
        if ($urandom % 4 != 0)
          rq($urandom % 32, $urandom % 32, ($urandom % 8 == 0) ? 0 : $urandom % 32, ($urandom % 6) == 0);
        pick_commits(ph == 0 ? 15 : 90);
        if (has_unres() && ($urandom % 5) == 0) begin
          res_valid = 1;
          res_mispredict = ($urandom % 3) == 0;
        end
        settle();
        tick();
      end
    end
    idle(); settle(); tick();
    finish_run();
  end
endmodule